// File: doc/BRIEF.md
# Character-Cell CRT Timing Controller

This block produces the raster timing for a text-mode display. All of its timing is programmed in character cells and scan lines, not in pixels. A dot counter splits the pixel clock into character clocks. A column counter sweeps each scan line and drives horizontal sync and horizontal display enable. A scan-line counter and a row counter then drive vertical sync and vertical display enable. The block brings out the current column, row and scan line so that downstream fetch and font logic can follow the beam.

Software programs the block through an indirect pair. With `bus_sel` low, a write stores a register index. With `bus_sel` high, a write goes to the indexed register, and `bus_rdata` always shows the indexed register. Timing writes are staged and reach the counters at the next scan-line boundary, so a line that is already under way keeps its old timing. A build option lets a displayed count of 0 stand for 256 cells, which allows a line to be fully visible 256 cells wide.

Top module: `cellcrtc`

## Requirements
- R1: While reset is asserted and after its release, with no register written yet, column, row and scan line read 0 and hsync, vsync and display_enable are low.
- R2: The column counts from 0 up to the line total (index 0, the total minus 1) and then wraps to 0. Each column lasts cell width (index 9, bits [3:0], width minus 1) plus 1 pixel clocks, so a line lasts (total+1)*(width+1) clocks.
- R3: Horizontal enable comes from a counter that is loaded at each line start with the displayed count (index 1) and decremented once per cell. The line is visible while that counter is non-zero, for displayed*(width+1) clocks. When ZERO_IS_256=1, a displayed count of 0 gives 256 visible cells. When ZERO_IS_256=0, it gives none.
- R4: hsync rises at the first clock of the column set by index 2 and stays high for the width in cells set by index 3 (bits [3:0]).
- R5: The scan line counts from 0 up to the row height (index 8, bits [4:0], height minus 1). The row counts from 0 up to the row total (index 4, rows minus 1). Vertical enable holds for rows below the displayed row count (index 5). display_enable is the AND of horizontal and vertical enable.
- R6: vsync rises at column 0 of scan line 0 of the row set by index 6 and stays high for the number of whole scan lines set by index 7 (bits [3:0]).
- R7: A timing write made during a scan line leaves that line unchanged and takes effect from the next line.
- R8: A write with bus_sel=0 selects the register index (bus_wdata[3:0]). With bus_sel=1, a write stores into the selected register. Read-back returns the stored value, with unused upper bits of narrow fields reading 0 and unassigned indices reading 0.
- R9: Index 15 is read-only and always returns the parameter REV. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Contents of the selected register |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| display_enable | output | 1 | Visible-area indicator |
| char_col | output | 8 | Current character column |
| char_row | output | 8 | Current character row |
| scan_line | output | 5 | Scan line within the current row |

## Verification
The bench goes after the displayed count of 0 on a 256-cell line. A design that tests the counter against zero in the naive way, without the wide load, would blank the whole line, and a build without the option must blank it. It measures line length, visible width and sync widths in pixel clocks with cells as wide as 16 pixels. A miscounted dot or column wrap would show up there as a line that is one cell or one pixel off. A mid-line write that shortens the line total must leave the current line at its old length, and a design that applies writes at once would wrap early. The bench also checks the vsync start position and the full frame length, and confirms that writes to the revision register are ignored and that narrow fields are masked.

// File: rtl/cellcrtc.sv
module cellcrtc #(
  parameter bit         ZERO_IS_256 = 1'b1,
  parameter logic [7:0] REV         = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       hsync,
  output logic       vsync,
  output logic       display_enable,
  output logic [7:0] char_col,
  output logic [7:0] char_row,
  output logic [4:0] scan_line
);
  logic [3:0] idx;
  logic [7:0] s_ht, s_hd, s_hp, s_vt, s_vd, s_vp;
  logic [3:0] s_hw, s_vw, s_cw;
  logic [4:0] s_ch;
  logic [7:0] a_ht, a_hp, a_vt, a_vd;
  logic [3:0] a_hw, a_cw;
  logic [4:0] a_ch;
  logic [3:0] dot, vs_cnt;
  logic [8:0] hcnt;

  wire       char_end = dot == a_cw;
  wire       line_end = char_end && char_col == a_ht;
  wire       row_end  = line_end && scan_line == a_ch;
  wire [7:0] row_nx   = row_end ? ((char_row == a_vt) ? 8'd0 : char_row + 8'd1) : char_row;
  wire [4:0] scan_nx  = row_end ? 5'd0 : scan_line + 5'd1;
  wire       vs_start = row_end && row_nx == s_vp;
  wire [8:0] hd_load  = (ZERO_IS_256 && s_hd == 8'd0) ? 9'd256 : {1'b0, s_hd};
  wire [7:0] hoff     = char_col - a_hp;

  assign hsync          = hoff < {4'b0, a_hw};
  assign vsync          = vs_cnt != 4'd0;
  assign display_enable = (hcnt != 9'd0) && (char_row < a_vd);

  always_comb begin
    case (idx)
      4'd0:    bus_rdata = s_ht;
      4'd1:    bus_rdata = s_hd;
      4'd2:    bus_rdata = s_hp;
      4'd3:    bus_rdata = {4'b0, s_hw};
      4'd4:    bus_rdata = s_vt;
      4'd5:    bus_rdata = s_vd;
      4'd6:    bus_rdata = s_vp;
      4'd7:    bus_rdata = {4'b0, s_vw};
      4'd8:    bus_rdata = {3'b0, s_ch};
      4'd9:    bus_rdata = {4'b0, s_cw};
      4'd15:   bus_rdata = REV;
      default: bus_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      s_ht <= '0; s_hd <= '0; s_hp <= '0; s_vt <= '0; s_vd <= '0; s_vp <= '0;
      s_hw <= '0; s_vw <= '0; s_cw <= '0; s_ch <= '0;
      a_ht <= '0; a_hp <= '0; a_vt <= '0; a_vd <= '0;
      a_hw <= '0; a_cw <= '0; a_ch <= '0;
    end else begin
      if (bus_wr && !bus_sel) idx <= bus_wdata[3:0];
      if (bus_wr && bus_sel) begin
        case (idx)
          4'd0: s_ht <= bus_wdata;
          4'd1: s_hd <= bus_wdata;
          4'd2: s_hp <= bus_wdata;
          4'd3: s_hw <= bus_wdata[3:0];
          4'd4: s_vt <= bus_wdata;
          4'd5: s_vd <= bus_wdata;
          4'd6: s_vp <= bus_wdata;
          4'd7: s_vw <= bus_wdata[3:0];
          4'd8: s_ch <= bus_wdata[4:0];
          4'd9: s_cw <= bus_wdata[3:0];
          default: ;
        endcase
      end
      if (line_end) begin
        a_ht <= s_ht; a_hp <= s_hp; a_hw <= s_hw; a_cw <= s_cw;
        a_vt <= s_vt; a_vd <= s_vd; a_ch <= s_ch;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot <= '0; hcnt <= '0; vs_cnt <= '0;
      char_col <= '0; char_row <= '0; scan_line <= '0;
    end else begin
      dot <= char_end ? 4'd0 : dot + 4'd1;
      if (line_end) begin
        char_col  <= 8'd0;
        hcnt      <= hd_load;
        scan_line <= scan_nx;
        char_row  <= row_nx;
        if (vs_start)            vs_cnt <= s_vw;
        else if (vs_cnt != 4'd0) vs_cnt <= vs_cnt - 4'd1;
      end else if (char_end) begin
        char_col <= char_col + 8'd1;
        if (hcnt != 9'd0) hcnt <= hcnt - 9'd1;
      end
    end
  end
endmodule

module cellcrtc_checker #(
  parameter logic [7:0] REV = 8'h21
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic [3:0] idx,
  input logic [7:0] bus_rdata,
  input logic       hsync,
  input logic       vsync,
  input logic [7:0] char_col,
  input logic [7:0] char_row,
  input logic [4:0] scan_line
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!hsync && !vsync && char_col == 8'd0 && char_row == 8'd0 && scan_line == 5'd0));

  assert_col_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (char_col == $past(char_col) || char_col == $past(char_col) + 8'd1 || char_col == 8'd0));

  assert_scan_at_line_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_line != $past(scan_line)) |-> char_col == 8'd0);

  assert_vsync_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (char_col == 8'd0 && scan_line == 5'd0));

  assert_revision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == 4'd15) |-> bus_rdata == REV);

  logic unused_sel;
  assign unused_sel = bus_sel;
endmodule

bind cellcrtc cellcrtc_checker #(.REV(REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .idx(idx), .bus_rdata(bus_rdata),
  .hsync(hsync), .vsync(vsync), .char_col(char_col), .char_row(char_row),
  .scan_line(scan_line)
);

// File: tb/cellcrtc_bench.sv
`timescale 1ns/1ps
module cellcrtc_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] rdata, rdata_p, col, row, col_p, row_p;
  logic hs, vs, de, hs_p, vs_p, de_p;
  logic [4:0] scan, scan_p;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  cellcrtc #(.ZERO_IS_256(1'b1), .REV(8'h21)) u_cellcrtc (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .hsync(hs), .vsync(vs), .display_enable(de),
    .char_col(col), .char_row(row), .scan_line(scan));

  cellcrtc #(.ZERO_IS_256(1'b0), .REV(8'h21)) u_cellcrtc_plain (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_p), .hsync(hs_p), .vsync(vs_p), .display_enable(de_p),
    .char_col(col_p), .char_row(row_p), .scan_line(scan_p));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] v);
    bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = {4'b0, i};
    @(negedge clk);
    bus_sel = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] v);
    bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = {4'b0, i};
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b1;
    #1 v = rdata;
    @(negedge clk);
  endtask

  task automatic cfg(input int ht, hd, hp, hw, cw, ch, vt, vd, vp, vw);
    wr(0, 8'(ht)); wr(1, 8'(hd)); wr(2, 8'(hp)); wr(3, 8'(hw)); wr(9, 8'(cw));
    wr(8, 8'(ch)); wr(4, 8'(vt)); wr(5, 8'(vd)); wr(6, 8'(vp)); wr(7, 8'(vw));
  endtask

  task automatic wait_hs_rise();
    logic p;
    p = hs;
    @(negedge clk);
    while (!(hs && !p)) begin p = hs; @(negedge clk); end
  endtask

  task automatic wait_vs_rise();
    logic p;
    p = vs;
    @(negedge clk);
    while (!(vs && !p)) begin p = vs; @(negedge clk); end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(col == 0 && row == 0 && scan == 0, "R1 counters in reset", int'(col) + int'(row) + int'(scan), 0);
    chk(!hs && !vs && !de, "R1 outputs in reset", int'({hs, vs, de}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(col == 0 && row == 0 && scan == 0, "R1 counters after reset", int'(col) + int'(row) + int'(scan), 0);
    chk(!hs && !vs && !de, "R1 outputs after reset", int'({hs, vs, de}), 0);
  endtask

  task automatic test_regs();
    logic [7:0] v;
    do_reset();
    wr(3, 8'hFF); rd(3, v); chk(v == 8'h0F, "R8 hsync width masked", v, 8'h0F);
    wr(8, 8'hFF); rd(8, v); chk(v == 8'h1F, "R8 row height masked", v, 8'h1F);
    wr(1, 8'hA5); rd(1, v); chk(v == 8'hA5, "R8 displayed readback", v, 8'hA5);
    wr(12, 8'h77); rd(12, v); chk(v == 8'h00, "R8 unassigned index", v, 0);
  endtask

  task automatic test_rev();
    logic [7:0] v;
    do_reset();
    rd(15, v); chk(v == 8'h21, "R9 revision value", v, 8'h21);
    wr(15, 8'h5A); rd(15, v); chk(v == 8'h21, "R9 revision write ignored", v, 8'h21);
  endtask

  task automatic test_line(input int ht, hd, hp, hw, cw);
    int n, dcnt, dpcnt, hcnt, exp_d, exp_dp;
    logic p;
    do_reset();
    cfg(ht, hd, hp, hw, cw, 0, 0, 1, 0, 0);
    wait_hs_rise();
    wait_hs_rise();
    chk(col == 8'(hp), "R4 hsync start column", col, hp);
    n = 0; dcnt = 0; dpcnt = 0; hcnt = 0; p = 1'b1;
    forever begin
      n++;
      if (de) dcnt++;
      if (de_p) dpcnt++;
      if (hs) hcnt++;
      p = hs;
      @(negedge clk);
      if (hs && !p) break;
    end
    exp_d  = (hd == 0 ? 256 : hd) * (cw + 1);
    exp_dp = hd * (cw + 1);
    chk(n == (ht + 1) * (cw + 1), "R2 line length", n, (ht + 1) * (cw + 1));
    chk(dcnt == exp_d, "R3 displayed width", dcnt, exp_d);
    chk(dpcnt == exp_dp, "R3 displayed width without zero option", dpcnt, exp_dp);
    chk(hcnt == hw * (cw + 1), "R4 hsync width", hcnt, hw * (cw + 1));
  endtask

  task automatic test_frame();
    int n, dcnt, vcnt, mscan, mrow;
    logic p;
    do_reset();
    cfg(3, 2, 2, 1, 1, 2, 4, 3, 3, 2);
    wait_vs_rise();
    wait_vs_rise();
    chk(col == 0 && scan == 0 && row == 3, "R6 vsync start position", row, 3);
    n = 0; dcnt = 0; vcnt = 0; mscan = 0; mrow = 0; p = 1'b1;
    forever begin
      n++;
      if (de) dcnt++;
      if (vs) vcnt++;
      if (int'(scan) > mscan) mscan = scan;
      if (int'(row) > mrow) mrow = row;
      p = vs;
      @(negedge clk);
      if (vs && !p) break;
    end
    chk(n == 120, "R5 frame length", n, 120);
    chk(dcnt == 36, "R5 visible area cycles", dcnt, 36);
    chk(vcnt == 16, "R6 vsync width", vcnt, 16);
    chk(mscan == 2, "R5 last scan line", mscan, 2);
    chk(mrow == 4, "R5 last row", mrow, 4);
  endtask

  task automatic test_boundary();
    int mx;
    do_reset();
    wr(9, 8'd0); wr(0, 8'd9);
    @(negedge clk);
    while (col != 8'd2) @(negedge clk);
    wr(0, 8'd3);
    mx = col;
    while (col != 8'd0) begin
      if (int'(col) > mx) mx = col;
      @(negedge clk);
    end
    chk(mx == 9, "R7 current line keeps old total", mx, 9);
    @(negedge clk);
    mx = 0;
    while (col != 8'd0) begin
      if (int'(col) > mx) mx = col;
      @(negedge clk);
    end
    chk(mx == 3, "R7 next line uses new total", mx, 3);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    test_reset();
    test_regs();
    test_rev();
    test_line(9, 6, 7, 2, 7);
    test_line(3, 4, 1, 1, 0);
    test_line(19, 16, 17, 2, 15);
    test_line(255, 0, 200, 8, 1);
    test_frame();
    test_boundary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule